// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This controller sequences the low-power states of a small microcontroller core. While the core is running, a single-cycle sleep strobe, together with a two-bit mode code, moves the controller into one of three sleep states. Each state drives its own pattern of clock enables: CPU, flash, I/O and ADC clocks, plus the oscillator enable. Each state also admits its own subset of wake-up sources. On entry to the two states that keep the ADC clock alive, a one-cycle conversion-start pulse is issued if the converter is enabled.

Leaving the idle or ADC-quiet states is immediate. Leaving power-down first restarts the oscillator, then holds every clock gated for a start-up interval. That interval is chosen by a two-bit clock-select input from a four-entry parameter table. The start-up counter is clocked by the restarted oscillator, which is modelled here as the block clock once `osc_en` is high. The oscillator, the converter and the reset logic lie outside this block. Reset-type wake sources reach it as ordinary wake lines.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, the controller is awake. All five enables (`cpu_clk_en`, `flash_clk_en`, `io_clk_en`, `adc_clk_en`, `osc_en`) and `active` are 1, and `adc_start` is 0.
- R2: Idle is entered with mode code 2'b00. In idle, the CPU and flash enables are 0 and the I/O, ADC and oscillator enables are 1.
- R3: ADC-quiet is entered with mode code 2'b01. In this state, the CPU, flash and I/O enables are 0 and the ADC and oscillator enables are 1.
- R4: Power-down is entered with mode code 2'b10. In power-down, all four clock enables and `osc_en` are 0.
- R5: In idle, any bit of `wake_src[8:0]` wakes the controller, and the clocks return in the cycle after the edge that samples it. Bit 8 stands for every other interrupt, such as a timer overflow or a serial overflow.
- R6: In ADC-quiet, only bits 0 to 7 of `wake_src` wake the controller, and bit 8 has no effect. The bits are: 0 external reset, 1 watchdog reset, 2 brown-out reset, 3 serial start condition, 4 low-level external interrupt, 5 pin change, 6 conversion complete, 7 EEPROM ready.
- R7: In power-down, only bits 0 to 5 of `wake_src` wake the controller, and bits 6, 7 and 8 have no effect.
- R8: `adc_start` is high for exactly one cycle, in the first cycle of idle or ADC-quiet, and only if `adc_enable` was high with the strobe. It is never raised on entry to power-down.
- R9: A power-down wake raises `osc_en` at once. The clock enables stay 0 for D cycles, with D = 6, 64, 512 or 4096 for `startup_sel` = 0, 1, 2 or 3. Wake events or strobes during this interval neither shorten nor extend it.
- R10: A sleep strobe with mode code 2'b11 is ignored, and the controller stays awake.
- R11: `active` equals `cpu_clk_en` in every cycle.
- R12: A sleep strobe that arrives while the controller is not awake has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (restarted oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep strobe |
| sleep_mode | input | 2 | Mode code sampled with the strobe |
| adc_enable | input | 1 | Converter enabled, sampled with the strobe |
| startup_sel | input | 2 | Clock-select code picking the start-up delay |
| wake_src | input | 9 | Wake source lines, bit map in R6 |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Oscillator enable |
| adc_start | output | 1 | One-cycle conversion start pulse |
| active | output | 1 | High while the CPU clock runs |

## Verification
The bench probes each state's wake mask with sources that must be refused. For example, it sends conversion-complete and EEPROM-ready in power-down and a timer-class interrupt in ADC-quiet. A mask that is too wide would wake the core early, and these probes would catch it. It measures the power-down start-up length for all four select codes and fires extra wakes and strobes mid-interval. This catches an off-by-one count, a restart of the counter, or an early release. It also covers the reserved mode code, strobes sent while asleep, and the converter-disabled case. A wrong design would go to sleep, change state, or issue a spurious conversion start in those cases.

// File: rtl/sleepctl_pkg.sv
package sleepctl_pkg;

    localparam int WAKE_W = 9;

    localparam int WK_EXT_RST  = 0;
    localparam int WK_WDT_RST  = 1;
    localparam int WK_BOR_RST  = 2;
    localparam int WK_SER_STRT = 3;
    localparam int WK_LVL_IRQ  = 4;
    localparam int WK_PIN_CHG  = 5;
    localparam int WK_ADC_DONE = 6;
    localparam int WK_EE_READY = 7;
    localparam int WK_OTHER    = 8;

    localparam logic [WAKE_W-1:0] MASK_PDOWN =
        (WAKE_W'(1) << WK_EXT_RST)  | (WAKE_W'(1) << WK_WDT_RST) |
        (WAKE_W'(1) << WK_BOR_RST)  | (WAKE_W'(1) << WK_SER_STRT) |
        (WAKE_W'(1) << WK_LVL_IRQ)  | (WAKE_W'(1) << WK_PIN_CHG);
    localparam logic [WAKE_W-1:0] MASK_ADCNR =
        MASK_PDOWN | (WAKE_W'(1) << WK_ADC_DONE) | (WAKE_W'(1) << WK_EE_READY);
    localparam logic [WAKE_W-1:0] MASK_IDLE = '1;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ADCNR   = 3'd2,
        ST_PDOWN   = 3'd3,
        ST_STARTUP = 3'd4
    } slp_state_e;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCNR = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_RSVD  = 2'b11
    } slp_mode_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } clk_gate_t;

    typedef struct packed {
        slp_state_e state;
        logic       adc_start;
    } ctl_t;

endpackage

// File: rtl/sleep_mode_dec.sv
module sleep_mode_dec
    import sleepctl_pkg::*;
(
    input  logic [1:0]  mode_code,
    input  logic        adc_on,
    output slp_state_e  target,
    output logic        mode_ok,
    output logic        auto_start
);

    always_comb begin
        target     = ST_AWAKE;
        mode_ok    = 1'b0;
        auto_start = 1'b0;
        unique case (slp_mode_e'(mode_code))
            MODE_IDLE: begin
                target     = ST_IDLE;
                mode_ok    = 1'b1;
                auto_start = adc_on;
            end
            MODE_ADCNR: begin
                target     = ST_ADCNR;
                mode_ok    = 1'b1;
                auto_start = adc_on;
            end
            MODE_PDOWN: begin
                target     = ST_PDOWN;
                mode_ok    = 1'b1;
            end
            MODE_RSVD: begin
                target     = ST_AWAKE;
            end
            default: begin
                target     = ST_AWAKE;
            end
        endcase
    end

endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual
    import sleepctl_pkg::*;
(
    input  slp_state_e         state,
    input  logic [WAKE_W-1:0]  wake_src,
    output logic               wake_hit
);

    logic [WAKE_W-1:0] mask;

    always_comb begin
        unique case (state)
            ST_IDLE:  mask = MASK_IDLE;
            ST_ADCNR: mask = MASK_ADCNR;
            ST_PDOWN: mask = MASK_PDOWN;
            default:  mask = '0;
        endcase
        wake_hit = |(wake_src & mask);
    end

endmodule

// File: rtl/sleep_clk_gate.sv
module sleep_clk_gate
    import sleepctl_pkg::*;
(
    input  slp_state_e state,
    output clk_gate_t  gate
);

    always_comb begin
        gate = '0;
        unique case (state)
            ST_AWAKE: begin
                gate = '1;
            end
            ST_IDLE: begin
                gate.io  = 1'b1;
                gate.adc = 1'b1;
                gate.osc = 1'b1;
            end
            ST_ADCNR: begin
                gate.adc = 1'b1;
                gate.osc = 1'b1;
            end
            ST_STARTUP: begin
                gate.osc = 1'b1;
            end
            default: begin
                gate = '0;
            end
        endcase
    end

endmodule

// File: rtl/sleep_startup_timer.sv
module sleep_startup_timer #(
    parameter int unsigned DLY0 = 6,
    parameter int unsigned DLY1 = 64,
    parameter int unsigned DLY2 = 512,
    parameter int unsigned DLY3 = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       expired
);

    localparam int unsigned DMAX01 = (DLY0 > DLY1) ? DLY0 : DLY1;
    localparam int unsigned DMAX23 = (DLY2 > DLY3) ? DLY2 : DLY3;
    localparam int unsigned DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
    localparam int          CNT_W  = $clog2(DMAX) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    function automatic logic [CNT_W-1:0] reload(input logic [1:0] s);
        unique case (s)
            2'd0:    return CNT_W'(DLY0 - 1);
            2'd1:    return CNT_W'(DLY1 - 1);
            2'd2:    return CNT_W'(DLY2 - 1);
            default: return CNT_W'(DLY3 - 1);
        endcase
    endfunction

    assign expired = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = reload(sel);
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import sleepctl_pkg::*;
#(
    parameter int unsigned DLY_SEL0 = 6,
    parameter int unsigned DLY_SEL1 = 64,
    parameter int unsigned DLY_SEL2 = 512,
    parameter int unsigned DLY_SEL3 = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [1:0]        sleep_mode,
    input  logic              adc_enable,
    input  logic [1:0]        startup_sel,
    input  logic [WAKE_W-1:0] wake_src,
    output logic              cpu_clk_en,
    output logic              flash_clk_en,
    output logic              io_clk_en,
    output logic              adc_clk_en,
    output logic              osc_en,
    output logic              adc_start,
    output logic              active
);

    ctl_t       ctl_d, ctl_q;
    slp_state_e tgt_state;
    logic       mode_ok;
    logic       auto_start;
    logic       wake_hit;
    logic       dly_load;
    logic       dly_done;
    clk_gate_t  gate;

    sleep_mode_dec u_dec (
        .mode_code  (sleep_mode),
        .adc_on     (adc_enable),
        .target     (tgt_state),
        .mode_ok    (mode_ok),
        .auto_start (auto_start)
    );

    sleep_wake_qual u_qual (
        .state    (ctl_q.state),
        .wake_src (wake_src),
        .wake_hit (wake_hit)
    );

    sleep_startup_timer #(
        .DLY0 (DLY_SEL0),
        .DLY1 (DLY_SEL1),
        .DLY2 (DLY_SEL2),
        .DLY3 (DLY_SEL3)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .sel     (startup_sel),
        .expired (dly_done)
    );

    sleep_clk_gate u_gate (
        .state (ctl_q.state),
        .gate  (gate)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.adc_start = 1'b0;
        dly_load        = 1'b0;
        unique case (ctl_q.state)
            ST_AWAKE: begin
                if (sleep_req && mode_ok) begin
                    ctl_d.state     = tgt_state;
                    ctl_d.adc_start = auto_start;
                end
            end
            ST_IDLE, ST_ADCNR: begin
                if (wake_hit) begin
                    ctl_d.state = ST_AWAKE;
                end
            end
            ST_PDOWN: begin
                if (wake_hit) begin
                    ctl_d.state = ST_STARTUP;
                    dly_load    = 1'b1;
                end
            end
            ST_STARTUP: begin
                if (dly_done) begin
                    ctl_d.state = ST_AWAKE;
                end
            end
            default: begin
                ctl_d.state = ST_AWAKE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_AWAKE, adc_start: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_clk_en   = gate.cpu;
    assign flash_clk_en = gate.flash;
    assign io_clk_en    = gate.io;
    assign adc_clk_en   = gate.adc;
    assign osc_en       = gate.osc;
    assign adc_start    = ctl_q.adc_start;
    assign active       = gate.cpu;

endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk
    import sleepctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic [1:0]        sleep_mode,
    input logic              adc_enable,
    input logic [WAKE_W-1:0] wake_src,
    input logic              cpu_clk_en,
    input logic              flash_clk_en,
    input logic              io_clk_en,
    input logic              adc_clk_en,
    input logic              osc_en,
    input logic              adc_start,
    input logic              active
);

    AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !(cpu_clk_en || flash_clk_en || io_clk_en || adc_clk_en)); // R4

    AST_CPU_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (flash_clk_en && io_clk_en && adc_clk_en && active)); // R11

    AST_IO_HOLDS_ADC: assert property (@(posedge clk) disable iff (!rst_n)
        io_clk_en |-> adc_clk_en); // R2

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R8

    AST_START_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (!cpu_clk_en && adc_clk_en && $past(adc_enable))); // R8

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_req && sleep_mode == 2'b11) |=> cpu_clk_en); // R10

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_clk_en && !cpu_clk_en && (|wake_src)) |=> cpu_clk_en); // R5

    AST_PD_NO_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !cpu_clk_en); // R9

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .sleep_mode   (sleep_mode),
    .adc_enable   (adc_enable),
    .wake_src     (wake_src),
    .cpu_clk_en   (cpu_clk_en),
    .flash_clk_en (flash_clk_en),
    .io_clk_en    (io_clk_en),
    .adc_clk_en   (adc_clk_en),
    .osc_en       (osc_en),
    .adc_start    (adc_start),
    .active       (active)
);

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [1:0] sleep_mode = 2'b00;
    logic       adc_enable = 1'b0;
    logic [1:0] startup_sel = 2'b00;
    logic [8:0] wake_src = '0;
    logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_en, adc_start, active;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state: 0 awake, 1 idle, 2 adc-quiet, 3 power-down, 4 start-up
    int m_state = 0;
    int m_left  = 0;
    bit m_start = 1'b0;

    always #5 clk = ~clk;

    sleep_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .adc_enable(adc_enable), .startup_sel(startup_sel), .wake_src(wake_src),
        .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
        .adc_clk_en(adc_clk_en), .osc_en(osc_en), .adc_start(adc_start), .active(active)
    );

    function automatic int delay_of(input int sel);
        case (sel)
            0: return 6;
            1: return 64;
            2: return 512;
            default: return 4096;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_start = 1'b0;
        end else begin
            m_start = 1'b0;
            case (m_state)
                0: if (sleep_req && sleep_mode != 2'b11) begin
                       m_state = sleep_mode + 1;
                       m_start = adc_enable && (sleep_mode < 2);
                   end
                1: if ((wake_src & 9'h1FF) != 0) m_state = 0;
                2: if ((wake_src & 9'h0FF) != 0) m_state = 0;
                3: if ((wake_src & 9'h03F) != 0) begin
                       m_state = 4; m_left = delay_of(startup_sel);
                   end
                default: begin
                    m_left--;
                    if (m_left == 0) m_state = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cpu_clk_en,   m_state == 0, "R2", "cpu_clk_en");
            chk(flash_clk_en, m_state == 0, "R2", "flash_clk_en");
            chk(io_clk_en,    m_state <= 1, "R3", "io_clk_en");
            chk(adc_clk_en,   m_state <= 2, "R3", "adc_clk_en");
            chk(osc_en,       m_state != 3, "R4", "osc_en");
            chk(adc_start,    m_start,      "R8", "adc_start");
            chk(active,       cpu_clk_en,   "R11", "active");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep(input logic [1:0] mode, input logic adc_on);
        sleep_req = 1'b1; sleep_mode = mode; adc_enable = adc_on;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake(input logic [8:0] bits);
        wake_src = bits;
        @(negedge clk);
        wake_src = '0;
    endtask

    task automatic pd_run(input int sel, input bit disturb);
        int n;
        go_sleep(2'b10, 1'b1);
        startup_sel = sel[1:0];
        wake_src = 9'(1) << (sel + 2);
        @(negedge clk);
        wake_src = '0;
        chk(osc_en, 1, "R9", "osc_en right after power-down wake");
        n = 1;
        while (!cpu_clk_en && n < 10000) begin
            if (disturb && n == 3) begin
                wake_src = 9'h001; sleep_req = 1'b1; sleep_mode = 2'b00;
            end else begin
                wake_src = '0; sleep_req = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        wake_src = '0; sleep_req = 1'b0;
        chk(n - 1, delay_of(sel), "R9", "start-up cycles with clocks gated");
    endtask

    initial begin
        tick(3);
        chk(cpu_clk_en & flash_clk_en & io_clk_en & adc_clk_en & osc_en, 1, "R1", "enables in reset");
        chk(adc_start, 0, "R1", "adc_start in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_clk_en & osc_en & active, 1, "R1", "awake after reset release");

        go_sleep(2'b00, 1'b1);
        chk(cpu_clk_en, 0, "R2", "idle cpu off");
        chk(io_clk_en & adc_clk_en & osc_en, 1, "R2", "idle io/adc/osc on");
        chk(adc_start, 1, "R8", "start pulse on idle entry");
        tick(1);
        chk(adc_start, 0, "R8", "start pulse one cycle");
        sleep_req = 1'b1; sleep_mode = 2'b01;
        tick(1);
        sleep_req = 1'b0;
        tick(1);
        chk(io_clk_en, 1, "R12", "strobe while idle ignored");
        pulse_wake(9'h100);
        chk(cpu_clk_en, 1, "R5", "idle wake by other interrupt");

        go_sleep(2'b00, 1'b0);
        tick(2);
        pulse_wake(9'h001);
        chk(cpu_clk_en, 1, "R5", "idle wake by external reset");

        go_sleep(2'b01, 1'b0);
        chk(io_clk_en, 0, "R3", "adc-quiet io off");
        chk(adc_clk_en & osc_en, 1, "R3", "adc-quiet adc/osc on");
        chk(adc_start, 0, "R8", "no start with converter disabled");
        pulse_wake(9'h100);
        tick(1);
        chk(cpu_clk_en, 0, "R6", "bit 8 ignored in adc-quiet");
        pulse_wake(9'h080);
        chk(cpu_clk_en, 1, "R6", "EEPROM ready wakes adc-quiet");

        go_sleep(2'b01, 1'b1);
        chk(adc_start, 1, "R8", "start pulse on adc-quiet entry");
        pulse_wake(9'h040);
        chk(cpu_clk_en, 1, "R6", "conversion complete wakes adc-quiet");

        go_sleep(2'b10, 1'b1);
        chk(adc_start, 0, "R8", "no start on power-down entry");
        chk(osc_en | adc_clk_en | io_clk_en | cpu_clk_en, 0, "R4", "power-down all off");
        pulse_wake(9'h040);
        pulse_wake(9'h080);
        pulse_wake(9'h100);
        tick(1);
        chk(osc_en, 0, "R7", "bits 6..8 ignored in power-down");
        pulse_wake(9'h020);
        chk(osc_en, 1, "R7", "pin change wakes power-down");
        tick(8);
        chk(cpu_clk_en, 1, "R7", "awake after pin change");

        pd_run(0, 1'b1);
        pd_run(1, 1'b0);
        pd_run(2, 1'b1);
        pd_run(3, 1'b0);

        go_sleep(2'b11, 1'b1);
        chk(cpu_clk_en, 1, "R10", "reserved code stays awake");
        chk(adc_start, 0, "R10", "reserved code no start");
        tick(2);
        chk(cpu_clk_en, 1, "R10", "still awake");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule